// File: doc/BRIEF.md
# Guarded Floating-Point Compare with Sticky Exception Flags

This block compares two IEEE-754 single-precision operands in one clock cycle and returns an integer 1 or 0. One magnitude comparator serves both directions. A less-than request is computed as a greater-than test with the two operands swapped. Denormal operands are flushed to zero before the comparison, and NaN operands force a result of 0. Each of these conditions raises its own exception flag.

The block keeps a two-bit sticky flag register. A compare sets it in the same cycle that it writes the result. Other floating-point units can OR their own flag updates into it in that cycle. Only an explicit status write clears it. A per-operation guard bit decides whether the operation has any architectural effect. A flags-only mode returns, as its result, the flags that a single compare would raise, and leaves the sticky register alone.

The operands arrive from the issue stage as a plain strobe (`issue`), not through a valid/ready pair. The block accepts one operation every cycle and cannot apply back-pressure. It therefore has no ready output.

Top module: `fcmp_sticky`

## Requirements
- R1: With `op_sel`=2'b00 (less-than), one cycle after an `issue` whose guard passes, `result_we` is 1. `result` is 32'd1 when A < B and 32'd0 otherwise. `result[31:2]` is always 0.
- R2: With `op_sel`=2'b01 (greater-than), `result` is 32'd1 when A > B and 32'd0 otherwise. The timing is the same as in R1.
- R3: An operand with exponent 0 and a non-zero fraction is compared as zero. It sets flag bit 1 (flushed-to-zero).
- R4: If either operand has exponent 255 and a non-zero fraction (quiet or signalling NaN), the result is 0 and flag bit 0 (invalid) is set.
- R5: +0 and -0 compare equal. Equal operands give 0 in both directions. -INF < +INF. Between two negative numbers, the one with the larger magnitude is the smaller.
- R6: Once set, a flag bit stays set until a status write clears it.
- R7: Only `guard[0]` matters. When it is 0, `result_we` is 0 in the next cycle, `result` keeps its value, and the compare makes no flag update.
- R8: The next flag value is the OR of the current flags, `flag_or_in`, and the guarded compare update. `flag_or_in` is applied whether or not an operation is issued.
- R9: When `stat_wr` is 1, the flags become `stat_wdata` in the next cycle. This overrides the compare update and `flag_or_in`.
- R10: With `op_sel[1]`=1 (2'b10 flags for less-than, 2'b11 flags for greater-than), `result` is {30'b0, flushed, invalid} for those operands. `result_we` follows the guard, and the sticky register takes no compare update.
- R11: After reset, `result`, `result_we` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op_sel | input | 2 | 00 less-than, 01 greater-than, 10/11 flags-only for the same |
| guard | input | 32 | Guard word; only bit 0 is used |
| opa | input | 32 | Operand A, single-precision |
| opb | input | 32 | Operand B, single-precision |
| flag_or_in | input | 2 | Simultaneous flag updates from other units |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Flag value loaded by a status write |
| result | output | 32 | Integer result |
| result_we | output | 1 | Destination write enable |
| flags | output | 2 | Sticky flags: bit 0 invalid, bit 1 flushed-to-zero |

## Verification
The hardest case to reach is a single cycle in which four things coincide: a guarded compare that raises a flag, a non-zero OR-in from another unit, a status write, and an already-set sticky state.

The bench sweeps every ordered pair of sixteen chosen encodings through all four operation selects. It cycles the guard word, the OR-in pattern and the status-write strobe at co-prime periods, so that these collisions happen many times with different flag histories. The bench computes the expected order from real-valued decodes of the bit fields. It models the sticky register with the priority rule stated in R9.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int NFLAG  = 2;
  localparam int FLG_INV = 0;
  localparam int FLG_FTZ = 1;

  typedef enum logic [1:0] {
    OP_LT       = 2'b00,
    OP_GT       = 2'b01,
    OP_LT_FLAGS = 2'b10,
    OP_GT_FLAGS = 2'b11
  } cmp_op_e;

  typedef struct packed {
    logic            is_nan;
    logic            flushed;
    logic [FP_W-1:0] key;
  } opnd_info_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [FP_W-1:0] val,
  output opnd_info_t      info
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic             ex_zero, ex_max, sgn;

  assign sgn     = val[FP_W-1];
  assign ex      = val[FP_W-2:MAN_W];
  assign fr      = val[MAN_W-1:0];
  assign ex_zero = ~|ex;
  assign ex_max  = &ex;

  always_comb begin
    info.is_nan  = ex_max & (|fr);
    info.flushed = ex_zero & (|fr);
    // Order-preserving unsigned key; every zero (flushed or signed) maps to +0.
    if (ex_zero)  info.key = {1'b1, {(FP_W-1){1'b0}}};
    else if (sgn) info.key = ~val;
    else          info.key = {1'b1, val[FP_W-2:0]};
  end
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
  import fcmp_pkg::*;
(
  input  opnd_info_t x,
  input  opnd_info_t y,
  output logic       gt,
  output logic       inv,
  output logic       ftz
);
  assign inv = x.is_nan | y.is_nan;
  assign ftz = x.flushed | y.flushed;
  assign gt  = ~inv & (x.key > y.key);
endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [NF-1:0] upd,
  input  logic [NF-1:0] or_in,
  input  logic          wr,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] merge;

  assign merge = flags | or_in | (upd_en ? upd : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flags <= '0;
    else if (wr) flags <= wdata;
    else         flags <= merge;
  end

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_or_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((flags & $past(or_in)) == $past(or_in)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (flags == $past(wdata)));
endmodule

// File: rtl/fcmp_sticky.sv
module fcmp_sticky
  import fcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [1:0]       op_sel,
  input  logic [31:0]      guard,
  input  logic [FP_W-1:0]  opa,
  input  logic [FP_W-1:0]  opb,
  input  logic [NFLAG-1:0] flag_or_in,
  input  logic             stat_wr,
  input  logic [NFLAG-1:0] stat_wdata,
  output logic [31:0]      result,
  output logic             result_we,
  output logic [NFLAG-1:0] flags
);
  logic [FP_W-1:0] opnd [2];
  opnd_info_t      info [2];
  opnd_info_t      cx, cy;
  logic            gt, inv, ftz, fire, flags_mode, swap;
  logic [NFLAG-1:0] upd;

  assign opnd[0] = opa;
  assign opnd[1] = opb;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify u_cls (.val(opnd[i]), .info(info[i]));
  end

  // Less-than reuses the greater-than path with operands exchanged.
  assign swap = (op_sel[0] == 1'b0);
  assign cx   = swap ? info[1] : info[0];
  assign cy   = swap ? info[0] : info[1];

  fcmp_core u_core (.x(cx), .y(cy), .gt(gt), .inv(inv), .ftz(ftz));

  assign fire       = issue & guard[0];
  assign flags_mode = op_sel[1];
  assign upd        = '{FLG_INV: inv, FLG_FTZ: ftz, default: 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
    end else begin
      result_we <= fire;
      if (fire) begin
        if (flags_mode) result <= {{(32-NFLAG){1'b0}}, upd};
        else            result <= {31'b0, gt};
      end
    end
  end

  fcmp_flag_reg #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .upd_en(fire & ~flags_mode), .upd(upd),
    .or_in(flag_or_in), .wr(stat_wr), .wdata(stat_wdata),
    .flags(flags)
  );

  assert_guard_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !guard[0]) |=> (!result_we && $stable(result)));

  assert_narrow_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    result[31:2] == '0);

  assert_nan_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !flags_mode && inv) |=> (result == 32'd0));

  assert_nan_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !flags_mode && inv && !stat_wr) |=> flags[FLG_INV]);
endmodule

// File: tb/test_fcmp_sticky.sv
module test_fcmp_sticky;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] guard = 32'h0;
  logic [31:0] opa = 32'h0, opb = 32'h0;
  logic [1:0]  flag_or_in = 2'b00;
  logic        stat_wr = 1'b0;
  logic [1:0]  stat_wdata = 2'b00;
  logic [31:0] result;
  logic        result_we;
  logic [1:0]  flags;

  int checks = 0, errors = 0;
  logic [1:0]  m_flags = 2'b00;
  logic [31:0] m_result = 32'h0;
  logic [31:0] vals [16];

  always #2.5 clk = ~clk;

  fcmp_sticky i_fcmp_sticky (.*);

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic bit is_den(input logic [31:0] v);
    return (v[30:23] == 8'h00) && (v[22:0] != 0);
  endfunction
  function automatic real fval(input logic [31:0] v);
    real m;
    int e;
    if (v[30:23] == 8'h00) return 0.0;
    if (v[30:23] == 8'hFF) return v[31] ? -1.0e300 : 1.0e300;
    m = 1.0 + real'(v[22:0]) / 8388608.0;
    e = int'(v[30:23]) - 127;
    if (e > 0) for (int i = 0; i < e; i++) m = m * 2.0;
    else       for (int i = 0; i < -e; i++) m = m / 2.0;
    return v[31] ? -m : m;
  endfunction

  task automatic do_op(input string tag, input logic iss, input logic [1:0] sel,
                       input logic [31:0] g, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] orin, input logic sw, input logic [1:0] swd);
    logic inv, ftz, cmp;
    logic [1:0] upd;
    real fa, fb;
    inv = is_nan(a) | is_nan(b);
    ftz = is_den(a) | is_den(b);
    fa = fval(a); fb = fval(b);
    cmp = !inv && (sel[0] ? (fa > fb) : (fa < fb));
    upd = {ftz, inv};
    issue = iss; op_sel = sel; guard = g; opa = a; opb = b;
    flag_or_in = orin; stat_wr = sw; stat_wdata = swd;
    @(posedge clk);
    if (iss && g[0]) m_result = sel[1] ? {30'b0, upd} : {31'b0, cmp};
    if (sw) m_flags = swd;
    else    m_flags = m_flags | orin | ((iss && g[0] && !sel[1]) ? upd : 2'b00);
    @(negedge clk);
    issue = 1'b0; stat_wr = 1'b0; flag_or_in = 2'b00;
    chk(tag, "result", result, m_result);
    chk(tag, "result_we", {31'b0, result_we}, {31'b0, iss && g[0]});
    chk(tag, "flags", {30'b0, flags}, {30'b0, m_flags});
  endtask

  initial begin
    vals = '{32'h00000000, 32'h80000000, 32'h00000001, 32'h80400000,
             32'h3f800000, 32'h40400000, 32'hbf800000, 32'hc0400000,
             32'h7f800000, 32'hff800000, 32'h7fc00000, 32'h7f800001,
             32'h7f7fffff, 32'h00800000, 32'h80800000, 32'h3f800001};
    #12 @(negedge clk);
    chk("R11", "reset result", result, 32'h0);
    chk("R11", "reset we", {31'b0, result_we}, 32'h0);
    chk("R11", "reset flags", {30'b0, flags}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    do_op("R5", 1, 2'b00, 32'h1, 32'h00000000, 32'h80000000, 2'b00, 0, 2'b00);
    do_op("R5", 1, 2'b01, 32'h1, 32'h80000000, 32'h00000000, 2'b00, 0, 2'b00);
    do_op("R5", 1, 2'b00, 32'h1, 32'h7f800000, 32'hff800000, 2'b00, 0, 2'b00);
    do_op("R5", 1, 2'b00, 32'h1, 32'hff800000, 32'h7f800000, 2'b00, 0, 2'b00);
    do_op("R5", 1, 2'b00, 32'h1, 32'hc0400000, 32'hbf800000, 2'b00, 0, 2'b00);
    do_op("R1", 1, 2'b00, 32'h1, 32'h3f800000, 32'h40400000, 2'b00, 0, 2'b00);
    do_op("R2", 1, 2'b01, 32'h1, 32'h40400000, 32'h3f800000, 2'b00, 0, 2'b00);
    do_op("R4", 1, 2'b00, 32'h1, 32'h40400000, 32'hffffffff, 2'b00, 0, 2'b00);
    do_op("R6", 1, 2'b00, 32'h1, 32'h3f800000, 32'h40400000, 2'b00, 0, 2'b00);
    do_op("R3", 1, 2'b00, 32'h1, 32'h3f800000, 32'h00400000, 2'b00, 0, 2'b00);
    do_op("R9", 1, 2'b00, 32'h1, 32'h7fc00000, 32'h00000001, 2'b11, 1, 2'b00);
    do_op("R7", 1, 2'b00, 32'hFFFFFFFE, 32'h7fc00000, 32'h00000001, 2'b00, 0, 2'b00);
    do_op("R8", 0, 2'b00, 32'h0, 32'h0, 32'h0, 2'b10, 0, 2'b00);
    do_op("R10", 1, 2'b10, 32'h1, 32'h7fc00000, 32'h00000001, 2'b00, 1, 2'b00);
    do_op("R10", 1, 2'b11, 32'h1, 32'h00000000, 32'h00000000, 2'b00, 0, 2'b00);

    // Sweep: every ordered pair, every select, with guard/or-in/status-write mixed in
    for (int k = 0; k < 1024; k++) begin
      logic [1:0]  sel, orin, swd;
      logic [31:0] a, b, g;
      logic        sw;
      string       tag;
      sel  = k[1:0];
      a    = vals[k[9:6]];
      b    = vals[k[5:2]];
      g    = (k % 7 == 3) ? 32'hFFFF_FFFE : ((k % 5 == 0) ? 32'h8000_0001 : 32'h1);
      orin = (k % 11 == 5) ? 2'(k % 3 + 1) : 2'b00;
      sw   = (k % 13 == 0);
      swd  = 2'(k % 4);
      if (sw)                         tag = "R9";
      else if (orin != 0)             tag = "R8";
      else if (!g[0])                 tag = "R7";
      else if (sel[1])                tag = "R10";
      else if (is_nan(a) | is_nan(b)) tag = "R4";
      else if (is_den(a) | is_den(b)) tag = "R3";
      else if (sel[0])                tag = "R2";
      else                            tag = "R1";
      do_op(tag, 1, sel, g, a, b, orin, sw, swd);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule